// File: doc/BRIEF.md
# Two-wire serial slave front end

This block is the bus-facing half of a small addressed peripheral on an I2C-style two-wire bus. It oversamples SCL and SDA with the system clock and finds the bus conditions on the synchronized copies. It assembles bytes MSB first and decides every acknowledge bit. Accepted command and data bytes go to a downstream command engine over a byte valid/ready port, and each byte carries a tag that says which slot of the transaction it came from. Read data comes back from the engine and is shifted out onto SDA.

A transaction opens with an 8-bit selection byte. Its upper nibble must equal a fixed type code, 0101 by default. Its lower nibble must equal the strapped `dev_addr_i` pins. If the byte matches and the engine is not busy, the slave acknowledges it. The slave then acknowledges a command byte. After that, one of two things happens. In a write, the slave receives and acknowledges one data byte. In a read, the engine asks for it at the end of the command acknowledge, and the slave shifts out one byte. While `busy_i` is high, the slave refuses the selection acknowledge, so the master can poll until an internal write has finished. The SDA output is open drain: `sda_oe_o` high pulls the line low.

Top module: `tw_slave_fe`

## Requirements
- R1: While reset is applied and in the first cycle after it, `sda_oe_o`, `rx_valid_o` and `txn_end_o` are all low.
- R2: Before any start condition (SDA falling while SCL is high), clocking a matching selection byte and a ninth pulse gets no acknowledge.
- R3: A selection byte is acknowledged when its upper four bits equal the type code 0101 and its lower four bits equal `dev_addr_i`. Acknowledge means SDA is pulled low for the whole ninth SCL pulse and released on the SCL fall that ends it. `sda_oe_o` changes only after an SCL fall.
- R4: When any bit of the selection byte differs, the slave gives no acknowledge and keeps SDA released. Later bytes are neither acknowledged nor handed on until the next start.
- R5: While `busy_i` is high at the eighth bit of the selection byte, that byte is not acknowledged. With `busy_i` low, a new start with the same byte is acknowledged.
- R6: The byte after an acknowledged selection byte is acknowledged and presented on `rx_data_o` with `rx_tag_o` = 2'b01 (command). The first bit on the bus becomes bit 7.
- R7: When `rd_en_i` is low at the end of the command acknowledge, the next byte is acknowledged and presented with `rx_tag_o` = 2'b10 (data).
- R8: Any byte after the data byte is not acknowledged and not presented.
- R9: When `rd_en_i` is high at the end of the command acknowledge, `tx_data_i` is driven MSB first, one bit per SCL low phase (a 0 bit pulls SDA low). SDA is released for the master's acknowledge pulse.
- R10: `rx_valid_o` and the presented byte hold until `rx_ready_i` is high. A byte that completes while the previous one is still unaccepted is not acknowledged, and it does not replace the held byte.
- R11: A start in the middle of a byte drops the partial byte, and the following byte is again treated as a selection byte.
- R12: A stop condition (SDA rising while SCL is high) ends the transaction. `txn_end_o` pulses for one clock only if the selection byte of that transaction was acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | High pulls SDA low |
| dev_addr_i | input | 4 | Strapped device address nibble |
| busy_i | input | 1 | Internal write in progress; refuses the selection acknowledge |
| rx_valid_o | output | 1 | A received byte is presented |
| rx_data_o | output | 8 | Presented byte |
| rx_tag_o | output | 2 | Byte slot: 01 command, 10 data |
| rx_ready_i | input | 1 | Engine takes the presented byte |
| rd_en_i | input | 1 | Engine requests a read byte after the command |
| tx_data_i | input | 8 | Byte to shift out on a read |
| txn_end_o | output | 1 | One-clock pulse at the stop of an acknowledged transaction |

## Verification
The bench tests selection bytes that differ only in the type nibble and only in the pin nibble. A comparator that checked just one of the two would acknowledge a foreign device. It polls with `busy_i` raised, where a slave that ignores busy would acknowledge too early. It ends a write with an extra fourth byte, where a slave that kept acknowledging would keep pulling SDA. It withholds `rx_ready_i` across a data byte, where a design without the overflow refusal would overwrite the held command. Last, it restarts in the middle of a byte, where a stale bit count would misalign the next selection byte and lose the acknowledge.

// File: rtl/tw_pkg.sv
package tw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADDR = 3'd1,
      ST_CMD  = 3'd2,
      ST_DATA = 3'd3,
      ST_RD   = 3'd4,
      ST_SKIP = 3'd5
   } tw_state_e;

   typedef enum logic [1:0] {
      TAG_NONE = 2'b00,
      TAG_CMD  = 2'b01,
      TAG_DATA = 2'b10
   } tw_tag_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
   } tw_ev_t;

   localparam int LINE_SDA = 0;
   localparam int LINE_SCL = 1;
   localparam int LINES    = 2;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= RST_VAL;
            else        chain_q <= d_i;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events
   import tw_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   scl_i,
   input  logic   sda_i,
   output tw_ev_t ev_o
);
   logic [LINES-1:0] raw;
   logic [LINES-1:0] now_s;
   logic [LINES-1:0] prev_q;

   assign raw[LINE_SCL] = scl_i;
   assign raw[LINE_SDA] = sda_i;

   generate
      for (genvar g = 0; g < LINES; g++) begin : g_line
         tw_line_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (raw[g]),
            .q_o  (now_s[g])
         );
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[g] <= 1'b1;
            else        prev_q[g] <= now_s[g];
         end
      end
   endgenerate

   logic scl_hi_both;
   assign scl_hi_both = now_s[LINE_SCL] & prev_q[LINE_SCL];

   always_comb begin
      ev_o.start = scl_hi_both &  prev_q[LINE_SDA] & ~now_s[LINE_SDA];
      ev_o.stop  = scl_hi_both & ~prev_q[LINE_SDA] &  now_s[LINE_SDA];
      ev_o.rise  =  now_s[LINE_SCL] & ~prev_q[LINE_SCL];
      ev_o.fall  = ~now_s[LINE_SCL] &  prev_q[LINE_SCL];
      ev_o.sda   =  now_s[LINE_SDA];
   end
endmodule

// File: rtl/tw_bit_engine.sv
module tw_bit_engine #(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = $clog2(BYTE_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              sda_i,
   output logic              byte_done_o,
   output logic [BYTE_W-1:0] byte_val_o,
   output logic              ack_start_o,
   output logic              ack_end_o,
   output logic              bit_fall_o
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] sh_q;
   logic              in_bits;

   assign in_bits     = (cnt_q < ACK_SLOT);
   assign byte_val_o  = {sh_q[BYTE_W-2:0], sda_i};
   assign byte_done_o = rise_i & (cnt_q == LAST_BIT);
   assign ack_start_o = fall_i & (cnt_q == ACK_SLOT);
   assign ack_end_o   = fall_i & (cnt_q == ACK_DONE);
   assign bit_fall_o  = fall_i & in_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (rise_i && in_bits) begin
         cnt_q <= cnt_q + CNT_W'(1);
         sh_q  <= byte_val_o;
      end else if (ack_start_o) begin
         cnt_q <= ACK_DONE;
      end else if (ack_end_o) begin
         cnt_q <= '0;
      end
   end
endmodule

// File: rtl/tw_rx_hold.sv
module tw_rx_hold
   import tw_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [BYTE_W-1:0] push_data_i,
   input  tw_tag_e           push_tag_i,
   output logic              room_o,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [BYTE_W-1:0] data_o,
   output tw_tag_e           tag_o
);
   assign room_o = ~valid_o | ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
         tag_o   <= TAG_NONE;
      end else if (push_i && room_o) begin
         valid_o <= 1'b1;
         data_o  <= push_data_i;
         tag_o   <= push_tag_i;
      end else if (valid_o && ready_i) begin
         valid_o <= 1'b0;
      end
   end
endmodule

// File: rtl/tw_slave_fe.sv
module tw_slave_fe
   import tw_pkg::*;
#(
   parameter int                        BYTE_W      = 8,
   parameter int                        ADDR_W      = 4,
   parameter int                        SYNC_STAGES = 2,
   parameter logic [BYTE_W-ADDR_W-1:0]  TYPE_CODE   = 'b0101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [ADDR_W-1:0] dev_addr_i,
   input  logic              busy_i,
   output logic              rx_valid_o,
   output logic [BYTE_W-1:0] rx_data_o,
   output logic [1:0]        rx_tag_o,
   input  logic              rx_ready_i,
   input  logic              rd_en_i,
   input  logic [BYTE_W-1:0] tx_data_i,
   output logic              txn_end_o
);
   localparam int TYPE_W = BYTE_W - ADDR_W;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tw_slave_fe: SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 1 || TYPE_W < 1) begin : g_bad_split
         $error("tw_slave_fe: address and type fields must both be non-empty");
      end
   endgenerate

   tw_ev_t            bus_ev;
   logic              scl_fall;
   logic              byte_done, ack_start, ack_end, bit_fall;
   logic [BYTE_W-1:0] byte_val;
   tw_state_e         state_q;
   logic              ack_pend_q;
   logic              matched_q;
   logic [BYTE_W-1:0] tx_q;
   logic              room;
   logic              push;
   logic              addr_hit;
   logic              active;
   tw_tag_e           push_tag;
   tw_tag_e           hold_tag;

   tw_bus_events #(.STAGES(SYNC_STAGES)) u_ev (
      .clk  (clk),
      .rst_n(rst_n),
      .scl_i(scl_i),
      .sda_i(sda_i),
      .ev_o (bus_ev)
   );

   assign scl_fall = bus_ev.fall;

   tw_bit_engine #(.BYTE_W(BYTE_W)) u_bits (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (bus_ev.start),
      .rise_i     (bus_ev.rise),
      .fall_i     (scl_fall),
      .sda_i      (bus_ev.sda),
      .byte_done_o(byte_done),
      .byte_val_o (byte_val),
      .ack_start_o(ack_start),
      .ack_end_o  (ack_end),
      .bit_fall_o (bit_fall)
   );

   assign addr_hit = (byte_val[BYTE_W-1 -: TYPE_W] == TYPE_CODE) &&
                     (byte_val[ADDR_W-1:0] == dev_addr_i) && !busy_i;
   assign active   = (state_q == ST_ADDR) || (state_q == ST_CMD) ||
                     (state_q == ST_DATA) || (state_q == ST_RD);
   assign push     = byte_done && ((state_q == ST_CMD) || (state_q == ST_DATA));
   assign push_tag = (state_q == ST_CMD) ? TAG_CMD : TAG_DATA;

   tw_rx_hold #(.BYTE_W(BYTE_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (push),
      .push_data_i(byte_val),
      .push_tag_i (push_tag),
      .room_o     (room),
      .ready_i    (rx_ready_i),
      .valid_o    (rx_valid_o),
      .data_o     (rx_data_o),
      .tag_o      (hold_tag)
   );

   assign rx_tag_o = hold_tag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         sda_oe_o   <= 1'b0;
         ack_pend_q <= 1'b0;
         matched_q  <= 1'b0;
         tx_q       <= '0;
         txn_end_o  <= 1'b0;
      end else begin
         txn_end_o <= 1'b0;
         if (bus_ev.start) begin
            state_q   <= ST_ADDR;
            sda_oe_o  <= 1'b0;
            matched_q <= 1'b0;
         end else if (bus_ev.stop) begin
            txn_end_o <= matched_q;
            state_q   <= ST_IDLE;
            sda_oe_o  <= 1'b0;
            matched_q <= 1'b0;
         end else if (active) begin
            if (byte_done) begin
               case (state_q)
                  ST_ADDR:         ack_pend_q <= addr_hit;
                  ST_CMD, ST_DATA: ack_pend_q <= room;
                  default:         ack_pend_q <= ack_pend_q;
               endcase
            end
            if (ack_start) begin
               sda_oe_o <= (state_q != ST_RD) && ack_pend_q;
            end
            if (bit_fall && (state_q == ST_RD)) begin
               sda_oe_o <= ~tx_q[BYTE_W-1];
               tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
            end
            if (ack_end) begin
               sda_oe_o <= 1'b0;
               case (state_q)
                  ST_ADDR: begin
                     state_q   <= ack_pend_q ? ST_CMD : ST_SKIP;
                     matched_q <= ack_pend_q;
                  end
                  ST_CMD: begin
                     if (!ack_pend_q) begin
                        state_q <= ST_SKIP;
                     end else if (rd_en_i) begin
                        state_q  <= ST_RD;
                        sda_oe_o <= ~tx_data_i[BYTE_W-1];
                        tx_q     <= {tx_data_i[BYTE_W-2:0], 1'b0};
                     end else begin
                        state_q <= ST_DATA;
                     end
                  end
                  default: state_q <= ST_SKIP;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/tw_slave_fe_chk.sv
module tw_slave_fe_chk
   import tw_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sda_oe_o,
   input logic              rx_valid_o,
   input logic [BYTE_W-1:0] rx_data_o,
   input logic [1:0]        rx_tag_o,
   input logic              rx_ready_i,
   input logic              txn_end_o,
   input logic              scl_fall,
   input tw_state_e         state_q
);
   // R2: no drive while idle
   assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !sda_oe_o);

   // R3 / R9: SDA is pulled low only as a result of an SCL fall
   assert_drive_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> $past(scl_fall));

   // R6 / R7: only the two slot tags are ever presented
   assert_tag_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> (rx_tag_o == TAG_CMD || rx_tag_o == TAG_DATA));

   // R10: a presented byte holds until taken
   assert_hold_until_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o) && $stable(rx_tag_o)));

   // R12: the end pulse lasts one clock
   assert_end_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      txn_end_o |=> !txn_end_o);
endmodule

bind tw_slave_fe tw_slave_fe_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sda_oe_o  (sda_oe_o),
   .rx_valid_o(rx_valid_o),
   .rx_data_o (rx_data_o),
   .rx_tag_o  (rx_tag_o),
   .rx_ready_i(rx_ready_i),
   .txn_end_o (txn_end_o),
   .scl_fall  (scl_fall),
   .state_q   (state_q)
);

// File: tb/tw_slave_fe_tb_top.sv
module tw_slave_fe_tb_top;
   localparam int Q = 4;
   localparam logic [3:0] MY_ADDR = 4'hA;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic sda_w;
   logic sda_oe;
   logic busy = 1'b0, ready = 1'b1, rd_en = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic rx_valid, txn_end;
   logic [7:0] rx_data;
   logic [1:0] rx_tag;

   int vectors = 0, miscompares = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   always #5 clk = ~clk;
   assign sda_w = m_sda & ~sda_oe;

   tw_slave_fe dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_w), .sda_oe_o(sda_oe),
      .dev_addr_i(MY_ADDR), .busy_i(busy), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
      .rx_tag_o(rx_tag), .rx_ready_i(ready), .rd_en_i(rd_en), .tx_data_i(tx_data),
      .txn_end_o(txn_end)
   );

   // ---------------- behavioural reference model ----------------
   bit m_s1c, m_s2c, m_qc, m_s1d, m_s2d, m_qd;
   int st, bits, sh, txv;
   bit ackp, matched, e_oe, e_valid, e_end;
   int e_data, e_tag;

   always @(posedge clk) begin
      if (!rst_n) begin
         {m_s1c, m_s2c, m_qc, m_s1d, m_s2d, m_qd} = 6'b111111;
         st = 0; bits = 0; sh = 0; txv = 0; ackp = 0; matched = 0;
         e_oe = 0; e_valid = 0; e_end = 0; e_data = 0; e_tag = 0;
      end else begin
         bit sc, pc, sd, pd, held;
         sc = m_s2c; pc = m_qc; sd = m_s2d; pd = m_qd;
         e_end = 0;
         held = e_valid && !ready;
         if (e_valid && ready) e_valid = 0;
         if (sc && pc && pd && !sd) begin
            st = 1; bits = 0; sh = 0; e_oe = 0; matched = 0;
         end else if (sc && pc && !pd && sd) begin
            e_end = matched; st = 0; e_oe = 0; matched = 0;
         end else if (st >= 1 && st <= 4) begin
            if (sc && !pc && bits < 8) begin
               sh = ((sh << 1) | int'(sd)) & 255;
               bits++;
               if (bits == 8) begin
                  if (st == 1)
                     ackp = ((sh >> 4) == 5) && ((sh & 15) == int'(MY_ADDR)) && !busy;
                  else if (st == 2 || st == 3) begin
                     if (held) ackp = 0;
                     else begin e_valid = 1; e_data = sh; e_tag = st - 1; ackp = 1; end
                  end
               end
            end else if (!sc && pc) begin
               if (bits < 8) begin
                  if (st == 4) e_oe = !txv[7 - bits];
               end else if (bits == 8) begin
                  e_oe = (st != 4) && ackp; bits = 9;
               end else begin
                  e_oe = 0; bits = 0;
                  case (st)
                     1: if (ackp) begin st = 2; matched = 1; end else st = 5;
                     2: if (!ackp) st = 5;
                        else if (rd_en) begin st = 4; txv = int'(tx_data); e_oe = !tx_data[7]; end
                        else st = 3;
                     default: st = 5;
                  endcase
               end
            end
         end
         m_qc = m_s2c; m_s2c = m_s1c; m_s1c = m_scl;
         m_qd = m_s2d; m_s2d = m_s1d; m_s1d = sda_w;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         vectors++;
         if (sda_oe !== e_oe || rx_valid !== e_valid || txn_end !== e_end ||
             (e_valid && (rx_data !== 8'(e_data) || rx_tag !== 2'(e_tag)))) begin
            miscompares++;
            $display("FAIL %s cycle compare: actual oe=%0b v=%0b d=%h t=%0d end=%0b expected oe=%0b v=%0b d=%h t=%0d end=%0b",
                     cur_req, sda_oe, rx_valid, rx_data, rx_tag, txn_end,
                     e_oe, e_valid, e_data[7:0], e_tag, e_end);
         end
      end
   end

   // transfer monitor
   int cap_n = 0, end_n = 0;
   logic [7:0] cap_data;
   logic [1:0] cap_tag;
   always @(posedge clk) begin
      if (rst_n && rx_valid && ready) begin cap_n++; cap_data = rx_data; cap_tag = rx_tag; end
      if (rst_n && txn_end) end_n++;
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wq(input int n); repeat (n) @(negedge clk); endtask

   task automatic bit_cycle(input logic b, output logic seen);
      m_sda = b; wq(Q);
      m_scl = 1'b1; wq(Q);
      seen = sda_w; wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic start_c;
      m_scl = 1'b0; wq(Q); m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic stop_c;
      m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) bit_cycle(v[i], s);
      bit_cycle(1'b1, s);
      acked = !s;
   endtask

   task automatic read_byte(output logic [7:0] v, input logic m_ack);
      logic s;
      for (int i = 7; i >= 0; i--) begin bit_cycle(1'b1, s); v[i] = s; end
      bit_cycle(!m_ack, s);
      chk(s == !m_ack, "R9", "SDA released in master ack slot", int'(s), int'(!m_ack));
   endtask

   logic a;
   logic [7:0] rv;
   int n0, e0;

   initial begin
      wq(6);
      rst_n = 1'b1;
      wq(1);
      cur_req = "R1";
      chk(!sda_oe && !rx_valid && !txn_end, "R1", "outputs after reset",
          int'({sda_oe, rx_valid, txn_end}), 0);

      cur_req = "R2";
      m_scl = 1'b0; wq(Q);
      send_byte(8'h5A, a);
      chk(!a, "R2", "no ack before any start", int'(a), 0);
      stop_c;

      cur_req = "R3";
      e0 = end_n;
      start_c; send_byte(8'h5A, a);
      chk(a, "R3", "selection ack", int'(a), 1);
      cur_req = "R6";
      send_byte(8'hC3, a);
      chk(a, "R6", "command ack", int'(a), 1);
      chk(cap_data == 8'hC3 && cap_tag == 2'b01, "R6", "command byte/tag",
          int'({cap_tag, cap_data}), 'h1C3);
      cur_req = "R7";
      send_byte(8'h96, a);
      chk(a, "R7", "data ack", int'(a), 1);
      chk(cap_data == 8'h96 && cap_tag == 2'b10, "R7", "data byte/tag",
          int'({cap_tag, cap_data}), 'h296);
      cur_req = "R8";
      n0 = cap_n;
      send_byte(8'h11, a);
      chk(!a, "R8", "extra byte ack", int'(a), 0);
      chk(cap_n == n0, "R8", "extra byte presented", cap_n, n0);
      cur_req = "R12";
      stop_c;
      chk(end_n == e0 + 1, "R12", "end pulse after acked txn", end_n, e0 + 1);

      cur_req = "R4";
      e0 = end_n; n0 = cap_n;
      start_c; send_byte(8'h7A, a);
      chk(!a, "R4", "type mismatch ack", int'(a), 0);
      send_byte(8'hC3, a);
      chk(!a && cap_n == n0, "R4", "byte after mismatch", int'(a) + cap_n - n0, 0);
      stop_c;
      chk(end_n == e0, "R12", "no end pulse without match", end_n, e0);
      start_c; send_byte(8'h5B, a);
      chk(!a, "R4", "pin address mismatch ack", int'(a), 0);
      stop_c;

      cur_req = "R5";
      busy = 1'b1;
      start_c; send_byte(8'h5A, a);
      chk(!a, "R5", "ack while busy", int'(a), 0);
      stop_c;
      busy = 1'b0;
      start_c; send_byte(8'h5A, a);
      chk(a, "R5", "ack after busy clears", int'(a), 1);
      stop_c;

      cur_req = "R9";
      e0 = end_n;
      rd_en = 1'b1; tx_data = 8'hA5;
      start_c; send_byte(8'h5A, a);
      send_byte(8'h9C, a);
      chk(a, "R9", "read command ack", int'(a), 1);
      read_byte(rv, 1'b0);
      chk(rv == 8'hA5, "R9", "read byte", int'(rv), 'hA5);
      stop_c;
      chk(end_n == e0 + 1, "R12", "end pulse after read", end_n, e0 + 1);
      rd_en = 1'b0;

      cur_req = "R10";
      ready = 1'b0;
      start_c; send_byte(8'h5A, a);
      send_byte(8'h21, a);
      chk(a, "R10", "command ack with engine stalled", int'(a), 1);
      send_byte(8'h44, a);
      chk(!a, "R10", "ack while previous unaccepted", int'(a), 0);
      chk(rx_valid && rx_data == 8'h21, "R10", "held byte",
          int'({rx_valid, rx_data}), 'h121);
      ready = 1'b1; wq(2);
      chk(!rx_valid && cap_data == 8'h21, "R10", "held byte taken",
          int'({rx_valid, cap_data}), 'h021);
      stop_c;

      cur_req = "R11";
      start_c;
      for (int i = 0; i < 4; i++) bit_cycle(i[0], a);
      start_c; send_byte(8'h5A, a);
      chk(a, "R11", "ack after mid-byte restart", int'(a), 1);
      send_byte(8'h88, a);
      chk(a && cap_data == 8'h88 && cap_tag == 2'b01, "R11", "command after restart",
          int'({a, cap_tag, cap_data}), 'h588);
      stop_c;
      wq(4);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         vectors++; miscompares++;
         $display("FAIL %s watchdog expired: actual running expected finished", cur_req);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule